// File: doc/BRIEF.md
# Signed Residue Scaler (divide by the product of the two lowest moduli)

The block divides a signed integer by the constant K = 27 * 29 = 783. The integer is held in residue form on the channel set {27, 29, 31, 32}, so the full ring size is M = 776736. An upstream mixed-radix converter supplies the two most significant mixed-radix digits, a3 (weight 783) and a4 (weight 24273), together with a sign flag. The block returns the residues of the scaled result on all four channels. The two lower mixed-radix digits are not needed, because their combined weight is below K. Dropping them truncates the quotient toward minus infinity, so the result is exactly floor(X / 783) and the error is always less than one unit.

The quotient has a range of M/K = 31 * 32 = 992 values. Each channel forms two candidate residues from small per-channel tables:
- 31*a4 + a3 for a nonnegative input;
- the same value minus 992 for a negative input.

A two-operand modulo adder combines the table outputs in each channel, and the sign flag selects between the two candidates per channel. Results come out two clock cycles after the input, with a valid flag. One input can be accepted every cycle.

Top module: `residue_scaler`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, out_valid is 0 and out_res is all zeros.
- R2: out_valid equals in_valid delayed by exactly two clock cycles. While out_valid is 0, out_res keeps its previous value, and changes to in_a3, in_a4 or in_neg without in_valid have no effect on it.
- R3: When in_neg is 0, each channel i outputs (31*a4 + a3) mod mi.
- R4: When in_neg is 1, each channel i outputs (31*a4 + a3 - 992) mod mi, taken as the least nonnegative residue.
- R5: For any signed X in [-388368, 388367] with N = X mod M, the inputs are a3 = (N / 783) mod 31, a4 = N / 24273 and in_neg = (a4 >= 16). The output residues then equal those of floor(X / 783).
- R6: The modulus-31 channel always outputs a3. The modulus-32 channel outputs (a3 - a4) mod 32. Neither channel depends on in_neg.
- R7: out_res packs the channels as follows: bits [4:0] hold the residue modulo 27, [9:5] modulo 29, [14:10] modulo 31 and [19:15] modulo 32. Every field is less than its modulus whenever out_valid is 1.
- R8: in_neg is 1 exactly when in_a4 >= 16 (the upper half of the top digit). Only in_neg selects the negative correction.
- R9: Inputs on consecutive cycles give results on consecutive cycles, in the same order, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input digits and sign are valid this cycle |
| in_a3 | input | 5 | Mixed-radix digit of weight 783 (0..30) |
| in_a4 | input | 5 | Mixed-radix digit of weight 24273 (0..31) |
| in_neg | input | 1 | Sign of the input number, 1 = negative |
| out_valid | output | 1 | Result residues valid |
| out_res | output | 20 | Residues of the scaled result, four 5-bit fields |

## Verification
The assertions check the following on every cycle:
- the two-cycle valid latency and the holding of out_res while no result is valid;
- that every output field stays below its modulus;
- that the sign flag agrees with the top digit;
- that the modulus-31 field equals the a3 digit applied two cycles before;
- that the negative candidate differs from the nonnegative one by the channel's correction.

Only the bench scenarios can show that the residue vector equals floor(X / 783) across the signed range. They cover the zero crossing, exact multiples of 783, the extreme values and back-to-back streaming.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int NUM_CH = 4;

    // least nonnegative residue of v modulo m
    function automatic int mod_norm(input int v, input int m);
        int r;
        r = v % m;
        if (r < 0) r = r + m;
        return r;
    endfunction

endpackage

// File: rtl/rsc_term_lut.sv
// Per-channel lookup of the weighted top digit, with and without the
// negative ring correction, plus reduction of the lower digit.
module rsc_term_lut #(
    parameter int CH_MOD = 27,
    parameter int MUL_K  = 31,
    parameter int CORR   = 0,
    parameter int RES_W  = 5
) (
    input  logic [RES_W-1:0] hi_digit,
    input  logic [RES_W-1:0] lo_digit,
    output logic [RES_W-1:0] term_pos,
    output logic [RES_W-1:0] term_neg,
    output logic [RES_W-1:0] lo_red
);
    localparam int DEPTH = 2 ** RES_W;

    logic [RES_W-1:0] tbl_pos [DEPTH];
    logic [RES_W-1:0] tbl_neg [DEPTH];
    logic [RES_W-1:0] tbl_lo  [DEPTH];

    for (genvar d = 0; d < DEPTH; d++) begin : g_tbl
        assign tbl_pos[d] = RES_W'((d * MUL_K) % CH_MOD);
        assign tbl_neg[d] = RES_W'((d * MUL_K + CORR) % CH_MOD);
        assign tbl_lo[d]  = RES_W'(d % CH_MOD);
    end

    assign term_pos = tbl_pos[hi_digit];
    assign term_neg = tbl_neg[hi_digit];
    assign lo_red   = tbl_lo[lo_digit];
endmodule

// File: rtl/rsc_mod_adder.sv
// Two-operand modulo adder for operands already below CH_MOD.
module rsc_mod_adder #(
    parameter int CH_MOD = 27,
    parameter int RES_W  = 5
) (
    input  logic [RES_W-1:0] op_a,
    input  logic [RES_W-1:0] op_b,
    output logic [RES_W-1:0] sum
);
    localparam logic [RES_W:0] MOD_W = (RES_W+1)'(CH_MOD);

    logic [RES_W:0] raw;

    always_comb begin
        raw = {1'b0, op_a} + {1'b0, op_b};
        if (raw >= MOD_W) raw = raw - MOD_W;
        sum = raw[RES_W-1:0];
    end
endmodule

// File: rtl/rsc_channel.sv
// One residue channel: table stage, then modulo add and sign select.
module rsc_channel
    import rsc_pkg::*;
#(
    parameter int CH_MOD = 27,
    parameter int MOD3   = 31,
    parameter int MOD4   = 32,
    parameter int RES_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_s1,
    input  logic             ld_s2,
    input  logic [RES_W-1:0] a3,
    input  logic [RES_W-1:0] a4,
    input  logic             neg,
    output logic [RES_W-1:0] res
);
    localparam int RANGE_Q = MOD3 * MOD4;
    localparam int CORR    = mod_norm(-RANGE_Q, CH_MOD);

    typedef struct packed {
        logic [RES_W-1:0] term_pos;
        logic [RES_W-1:0] term_neg;
        logic [RES_W-1:0] lo;
        logic             neg;
    } s1_t;

    typedef struct packed {
        s1_t              s1;
        logic [RES_W-1:0] res;
    } st_t;

    st_t st_d, st_q;

    logic [RES_W-1:0] lut_pos, lut_neg, lut_lo;
    logic [RES_W-1:0] sum_pos, sum_neg;

    rsc_term_lut #(.CH_MOD(CH_MOD), .MUL_K(MOD3), .CORR(CORR), .RES_W(RES_W)) u_lut (
        .hi_digit (a4),
        .lo_digit (a3),
        .term_pos (lut_pos),
        .term_neg (lut_neg),
        .lo_red   (lut_lo)
    );

    rsc_mod_adder #(.CH_MOD(CH_MOD), .RES_W(RES_W)) u_add_pos (
        .op_a (st_q.s1.term_pos),
        .op_b (st_q.s1.lo),
        .sum  (sum_pos)
    );

    rsc_mod_adder #(.CH_MOD(CH_MOD), .RES_W(RES_W)) u_add_neg (
        .op_a (st_q.s1.term_neg),
        .op_b (st_q.s1.lo),
        .sum  (sum_neg)
    );

    always_comb begin
        st_d = st_q;
        if (ld_s1) begin
            st_d.s1.term_pos = lut_pos;
            st_d.s1.term_neg = lut_neg;
            st_d.s1.lo       = lut_lo;
            st_d.s1.neg      = neg;
        end
        if (ld_s2) begin
            st_d.res = st_q.s1.neg ? sum_neg : sum_pos;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res = st_q.res;

    // R7: a freshly loaded result is always a proper residue
    assert_res_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_s2 |=> (int'(res) < CH_MOD));

    // R4: negative candidate is offset from the nonnegative one by -M/K mod m
    assert_neg_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_s2 |-> (((int'(sum_neg) + CH_MOD - int'(sum_pos)) % CH_MOD) == CORR));
endmodule

// File: rtl/residue_scaler.sv
module residue_scaler
    import rsc_pkg::*;
#(
    parameter int MOD1  = 27,
    parameter int MOD2  = 29,
    parameter int MOD3  = 31,
    parameter int MOD4  = 32,
    parameter int RES_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [RES_W-1:0]        in_a3,
    input  logic [RES_W-1:0]        in_a4,
    input  logic                    in_neg,
    output logic                    out_valid,
    output logic [NUM_CH*RES_W-1:0] out_res
);
    localparam int CH_MODS [NUM_CH] = '{MOD1, MOD2, MOD3, MOD4};
    localparam int SIGN_TH = MOD4 / 2;

    typedef struct packed {
        logic v1;
        logic v2;
    } vpipe_t;

    vpipe_t vp_d, vp_q;

    always_comb begin
        vp_d    = vp_q;
        vp_d.v1 = in_valid;
        vp_d.v2 = vp_q.v1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vp_q <= '0;
        else        vp_q <= vp_d;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        rsc_channel #(
            .CH_MOD (CH_MODS[g]),
            .MOD3   (MOD3),
            .MOD4   (MOD4),
            .RES_W  (RES_W)
        ) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .ld_s1 (in_valid),
            .ld_s2 (vp_q.v1),
            .a3    (in_a3),
            .a4    (in_a4),
            .neg   (in_neg),
            .res   (out_res[g*RES_W +: RES_W])
        );
    end

    assign out_valid = vp_q.v2;

    // R2: two-cycle latency of the valid flag
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);
    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R2: result held while nothing new is valid
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_res));

    // R8: sign flag agrees with the upper half of the top digit
    assert_sign_consistent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (in_neg == (int'(in_a4) >= SIGN_TH)));

    // R6: the modulus-31 channel reproduces the a3 digit
    assert_m3_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_res[2*RES_W +: RES_W] == $past(in_a3, 2)));
endmodule

// File: tb/residue_scaler_test.sv
module residue_scaler_test;

    localparam int MR   = 776736;
    localparam int KS   = 783;
    localparam int W4   = 24273;
    localparam int MODS [4] = '{27, 29, 31, 32};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_a3 = '0;
    logic [4:0]  in_a4 = '0;
    logic        in_neg = 1'b0;
    logic        out_valid;
    logic [19:0] out_res;

    int nvec = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    residue_scaler uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_a3     (in_a3),
        .in_a4     (in_a4),
        .in_neg    (in_neg),
        .out_valid (out_valid),
        .out_res   (out_res)
    );

    function automatic int nmod(int v, int m);
        int r;
        r = v % m;
        if (r < 0) r += m;
        return r;
    endfunction

    function automatic int floor_div(int x);
        int q;
        q = x / KS;
        if ((x % KS != 0) && (x < 0)) q -= 1;
        return q;
    endfunction

    function automatic logic [19:0] exp_res(int x);
        logic [19:0] r;
        int q;
        q = floor_div(x);
        for (int i = 0; i < 4; i++) r[i*5 +: 5] = 5'(nmod(q, MODS[i]));
        return r;
    endfunction

    task automatic drive_x(int x);
        int n;
        n = nmod(x, MR);
        in_a3  = 5'((n / KS) % 31);
        in_a4  = 5'(n / W4);
        in_neg = (n / W4) >= 16;
    endtask

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // R1: reset state
    task automatic t_reset;
        check("R1 valid in reset", 32'(out_valid), 32'd0);
        check("R1 res in reset", 32'(out_res), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", 32'(out_valid), 32'd0);
        check("R1 res after reset", 32'(out_res), 32'd0);
    endtask

    // one value, checked two cycles later
    task automatic t_single(int x, string req);
        @(negedge clk);
        drive_x(x);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check({req, " residues"}, 32'(out_res), 32'(exp_res(x)));
    endtask

    // R3 / R4 / R5 corner values
    task automatic t_corners;
        t_single(0, "R3 zero");
        t_single(782, "R3 below K");
        t_single(783, "R3 exact K");
        t_single(388367, "R3 max positive");
        t_single(-1, "R4 minus one");
        t_single(-783, "R4 minus K");
        t_single(-784, "R4 below minus K");
        t_single(-388368, "R4 min negative");
        t_single(388367 - 782, "R5 top quotient");
        t_single(-388368 + 782, "R5 bottom quotient");
    endtask

    // R6: channels 31 and 32 ignore the sign
    task automatic t_sign_free;
        int xs [4] = '{12345, -12345, 200000, -300001};
        foreach (xs[k]) begin
            int n, a3, a4;
            n  = nmod(xs[k], MR);
            a3 = (n / KS) % 31;
            a4 = n / W4;
            t_single(xs[k], "R6 vector");
            check("R6 mod31 equals a3", 32'(out_res[14:10]), 32'(a3));
            check("R6 mod32 equals a3-a4", 32'(out_res[19:15]), 32'(nmod(a3 - a4, 32)));
            check("R7 field mod27 range", 32'(out_res[4:0] < 5'd27), 32'd1);
        end
    endtask

    // R2: no valid means no change
    task automatic t_hold;
        logic [19:0] prev;
        t_single(-5000, "R2 setup");
        prev = out_res;
        @(negedge clk);
        in_a3 = 5'd7; in_a4 = 5'd20; in_neg = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 no valid out", 32'(out_valid), 32'd0);
        check("R2 held residues", 32'(out_res), 32'(prev));
    endtask

    // R5 / R9: back-to-back sweep over the signed range
    task automatic t_sweep(int step);
        logic [19:0] ring [3];
        int total, idx;
        total = 0;
        for (int x = -388368; x <= 388367; x += step) total++;
        idx = 0;
        for (int k = 0; k < total + 2; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                check("R9 stream valid", 32'(out_valid), 32'd1);
                check("R5 sweep residues", 32'(out_res), 32'(ring[(k-2)%3]));
            end
            if (k < total) begin
                int x;
                x = -388368 + k * step;
                drive_x(x);
                in_valid = 1'b1;
                ring[k%3] = exp_res(x);
            end else begin
                in_valid = 1'b0;
            end
            idx++;
        end
        @(negedge clk);
        check("R2 stream end", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_corners();
        t_sign_free();
        t_hold();
        t_sweep(41);
        t_sweep(997);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule